// File: doc/BRIEF.md
# Half-Word Instruction Aligner

The block sits between a prefetch queue that returns only word-aligned 32-bit words and the decode stage. Instructions are either 16-bit compressed or 32-bit long, and they may begin on any half-word. The aligner cuts whole instructions out of the word stream and hands each one to decode along with its program counter. It also tells decode whether the instruction is compressed.

Each word splits into a lower and an upper half. When the upper half cannot go out in the same cycle, a one-entry residual register holds it. A 32-bit instruction that starts in the upper half of one word is built from that saved half and the lower half of the next word. A compressed instruction left in the residual register goes out without taking a new word. On average, a stream with compressed code therefore takes fewer than one fetch word per instruction. A redirect loads a new program counter and drops the residual. If the target sits at a half-word offset, the lower half of the first word fetched afterwards is discarded.

Both edges use a valid/ready handshake. A word moves when `fetchValid` and `fetchReady` are both high at a rising edge. An instruction moves when `outValid` and `outReady` are both high at a rising edge.

Top module: `half_aligner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` is low. The first instruction delivered without a redirect carries the PC `BOOT_ADDR`.
- R2: A half-word whose bits [1:0] are 2'b11 starts a 32-bit instruction. Any other half-word is a complete compressed instruction. It is shown with `outCompressed` high and `outInstr` = {16'h0000, half}.
- R3: When no residual is held and the lower half of the incoming word starts a 32-bit instruction, the whole word is delivered. The word is consumed at the handshake.
- R4: When no residual is held and the lower half of the incoming word is compressed, that half is delivered. At the handshake the word is consumed and its upper half is kept as the residual.
- R5: A compressed residual is delivered without taking a new word. `fetchReady` stays low while it is shown.
- R6: A 32-bit instruction that starts in a residual half is delivered as {next word bits [15:0], residual}. `outValid` is high only while that next word is presented. A 32-bit start with no following word is never delivered.
- R7: In a cycle with `redirValid` high, `outValid` and `fetchReady` are low. Any residual is discarded. The next instruction carries the PC `redirPc` with bit 0 cleared.
- R8: After a redirect whose target has bit 1 set, the lower half of the first word received is dropped. The first instruction begins at that word's upper half.
- R9: While `outValid` is high and `outReady` is low, no instruction is consumed and `outPc` holds its value.
- R10: After each delivered instruction, the PC advances by 2 for a compressed instruction and by 4 for a 32-bit one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetched word is presented |
| fetchWord | input | 32 | Word-aligned fetched word |
| fetchReady | output | 1 | The presented word is taken at this edge |
| redirValid | input | 1 | Load a new program counter |
| redirPc | input | ADDR_W | Redirect target; bit 0 ignored |
| outValid | output | 1 | A complete instruction is shown |
| outReady | input | 1 | Decode accepts the shown instruction |
| outInstr | output | 32 | Instruction, compressed ones zero-extended |
| outPc | output | ADDR_W | Address of the shown instruction |
| outCompressed | output | 1 | Shown instruction is 16 bits long |

## Verification
Some rules are checked by assertions on every cycle:
- the PC step of 2 or 4 after each handshake, and the PC holding its value otherwise;
- the loading of the redirect target;
- the quiet redirect cycle;
- a compressed residual never pulling a word;
- a stitched instruction never shown valid without a word behind it;
- the shape of compressed output.

Other behaviour can only be shown by the bench's scenarios. These are the correct content and order of the stitched instructions, the half-word dropped after a redirect to a half-word offset, the residual being thrown away on redirect, and a dangling 32-bit start staying hidden. The bench exercises them with word gaps and decode stalls.

// File: rtl/half_aligner_pkg.sv
`timescale 1ns/1ps
package half_aligner_pkg;

  localparam int ILEN = 32;
  localparam int HLEN = ILEN / 2;

  // source of the instruction shown to decode
  typedef enum logic [1:0] {
    SEL_FULL   = 2'd0,  // whole incoming word
    SEL_LOW_C  = 2'd1,  // compressed lower half of incoming word
    SEL_RES_C  = 2'd2,  // compressed residual half
    SEL_STITCH = 2'd3   // {incoming lower half, residual half}
  } outSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    redirect;      // load new PC
    logic    fire;          // instruction handshake this cycle
    logic    step4;         // delivered instruction is 32-bit
    logic    captureUpper;  // store incoming upper half as residual
    outSel_e sel;
  } strobe_t;

  function automatic logic isCompressed(input logic [HLEN-1:0] half);
    return half[1:0] != 2'b11;
  endfunction

endpackage

// File: rtl/half_aligner_ctrl.sv
`timescale 1ns/1ps
module half_aligner_ctrl
  import half_aligner_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    fetchValid,
  output logic    fetchReady,
  input  logic    redirValid,
  input  logic    redirBit1,
  output logic    outValid,
  input  logic    outReady,
  input  logic    lowIsComp,
  input  logic    resIsComp,
  output strobe_t st
);

  logic resValidQ;  // residual half register holds a live half
  logic skipLowQ;   // drop lower half of the next word

  always_comb begin
    st         = '0;
    st.sel     = SEL_FULL;
    fetchReady = 1'b0;
    outValid   = 1'b0;
    if (redirValid) begin
      st.redirect = 1'b1;
    end else if (resValidQ) begin
      if (resIsComp) begin
        st.sel   = SEL_RES_C;
        outValid = 1'b1;
        st.fire  = outReady;
      end else begin
        st.sel          = SEL_STITCH;
        outValid        = fetchValid;
        fetchReady      = outReady;
        st.fire         = fetchValid & outReady;
        st.step4        = 1'b1;
        st.captureUpper = fetchValid & outReady;
      end
    end else if (skipLowQ) begin
      fetchReady      = 1'b1;
      st.captureUpper = fetchValid;
    end else begin
      st.sel          = lowIsComp ? SEL_LOW_C : SEL_FULL;
      outValid        = fetchValid;
      fetchReady      = outReady;
      st.fire         = fetchValid & outReady;
      st.step4        = ~lowIsComp;
      st.captureUpper = fetchValid & outReady & lowIsComp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValidQ <= 1'b0;
      skipLowQ  <= 1'b0;
    end else if (st.redirect) begin
      resValidQ <= 1'b0;
      skipLowQ  <= redirBit1;
    end else begin
      if (st.captureUpper) begin
        resValidQ <= 1'b1;
        skipLowQ  <= 1'b0;
      end else if (st.fire) begin
        resValidQ <= 1'b0;
      end
    end
  end

  // R7: redirect cycle shows nothing and takes nothing
  a_r7_quiet_redirect: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> (!outValid && !fetchReady));

  // R7: residual gone after a redirect
  a_r7_residual_dropped: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> !resValidQ);

  // R5: compressed residual never pulls a word
  a_r5_no_pull: assert property (@(posedge clk) disable iff (!rstN)
    (resValidQ && resIsComp && !redirValid) |-> !fetchReady);

  // R6: stitched instruction valid only with a word behind it
  a_r6_stitch_has_word: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && st.sel == SEL_STITCH) |-> fetchValid);

  // R6: stitching keeps the next upper half as residual
  a_r6_stitch_refills: assert property (@(posedge clk) disable iff (!rstN)
    (st.fire && st.sel == SEL_STITCH && !redirValid) |=> resValidQ);

  // R8: the dropped half never reaches decode
  a_r8_skip_silent: assert property (@(posedge clk) disable iff (!rstN)
    (skipLowQ && !resValidQ && !redirValid) |-> !outValid);

endmodule

// File: rtl/half_aligner_dpath.sv
`timescale 1ns/1ps
module half_aligner_dpath
  import half_aligner_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [ILEN-1:0]   fetchWord,
  input  logic [ADDR_W-1:0] redirPc,
  output logic              lowIsComp,
  output logic              resIsComp,
  output logic [ILEN-1:0]   outInstr,
  output logic [ADDR_W-1:0] outPc,
  output logic              outCompressed
);

  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(HLEN / 8);
  localparam logic [ADDR_W-1:0] STEP_FULL = ADDR_W'(ILEN / 8);
  localparam logic [ADDR_W-1:0] EVEN_MASK = ~ADDR_W'(1);

  logic [ADDR_W-1:0] pcQ;
  logic [HLEN-1:0]   resHalfQ;
  logic [HLEN-1:0]   lowHalf;
  logic [HLEN-1:0]   highHalf;

  assign lowHalf   = fetchWord[HLEN-1:0];
  assign highHalf  = fetchWord[ILEN-1:HLEN];
  assign lowIsComp = isCompressed(lowHalf);
  assign resIsComp = isCompressed(resHalfQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= BOOT_ADDR & EVEN_MASK;
    end else if (st.redirect) begin
      pcQ <= redirPc & EVEN_MASK;
    end else if (st.fire) begin
      pcQ <= pcQ + (st.step4 ? STEP_FULL : STEP_HALF);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resHalfQ <= '0;
    end else if (st.captureUpper) begin
      resHalfQ <= highHalf;
    end
  end

  always_comb begin
    unique case (st.sel)
      SEL_LOW_C:  outInstr = {{HLEN{1'b0}}, lowHalf};
      SEL_RES_C:  outInstr = {{HLEN{1'b0}}, resHalfQ};
      SEL_STITCH: outInstr = {lowHalf, resHalfQ};
      default:    outInstr = fetchWord;
    endcase
  end

  assign outCompressed = (st.sel == SEL_LOW_C) || (st.sel == SEL_RES_C);
  assign outPc         = pcQ;

  // R10: PC step follows the delivered length
  a_r10_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (st.fire && !st.redirect) |=> pcQ == $past(pcQ) + ($past(st.step4) ? STEP_FULL : STEP_HALF));

  // R9: PC frozen without a handshake or redirect
  a_r9_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!st.fire && !st.redirect) |=> $stable(pcQ));

  // R7: redirect loads the even target
  a_r7_pc_load: assert property (@(posedge clk) disable iff (!rstN)
    st.redirect |=> pcQ == ($past(redirPc) & EVEN_MASK));

  // R2: compressed output is zero-extended and not a 32-bit start
  a_r2_comp_shape: assert property (@(posedge clk) disable iff (!rstN)
    outCompressed |-> (outInstr[1:0] != 2'b11 && outInstr[ILEN-1:HLEN] == '0));

endmodule

// File: rtl/half_aligner.sv
`timescale 1ns/1ps
module half_aligner
  import half_aligner_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = ADDR_W'(32'h80)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [31:0]       fetchWord,
  output logic              fetchReady,
  input  logic              redirValid,
  input  logic [ADDR_W-1:0] redirPc,
  output logic              outValid,
  input  logic              outReady,
  output logic [31:0]       outInstr,
  output logic [ADDR_W-1:0] outPc,
  output logic              outCompressed
);

  strobe_t st;
  logic    lowIsComp;
  logic    resIsComp;

  half_aligner_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .fetchReady (fetchReady),
    .redirValid (redirValid),
    .redirBit1  (redirPc[1]),
    .outValid   (outValid),
    .outReady   (outReady),
    .lowIsComp  (lowIsComp),
    .resIsComp  (resIsComp),
    .st         (st)
  );

  half_aligner_dpath #(
    .ADDR_W    (ADDR_W),
    .BOOT_ADDR (BOOT_ADDR)
  ) i_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .st            (st),
    .fetchWord     (fetchWord),
    .redirPc       (redirPc),
    .lowIsComp     (lowIsComp),
    .resIsComp     (resIsComp),
    .outInstr      (outInstr),
    .outPc         (outPc),
    .outCompressed (outCompressed)
  );

endmodule

// File: tb/test_half_aligner.sv
`timescale 1ns/1ps
module test_half_aligner;

  localparam int          ADDR_W = 32;
  localparam logic [31:0] BOOT   = 32'h80;

  logic        clk = 1'b0;
  logic        rstN;
  logic        fetchValid;
  logic [31:0] fetchWord;
  logic        fetchReady;
  logic        redirValid;
  logic [31:0] redirPc;
  logic        outValid;
  logic        outReady;
  logic [31:0] outInstr;
  logic [31:0] outPc;
  logic        outCompressed;

  always #2.5 clk = ~clk;

  half_aligner #(.ADDR_W(ADDR_W), .BOOT_ADDR(BOOT)) i_half_aligner (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchWord(fetchWord),
    .fetchReady(fetchReady), .redirValid(redirValid), .redirPc(redirPc),
    .outValid(outValid), .outReady(outReady), .outInstr(outInstr),
    .outPc(outPc), .outCompressed(outCompressed)
  );

  typedef struct {
    logic [31:0] instr;
    logic [31:0] pc;
    bit          comp;
    bit          fromRes;
    string       tag;
    string       pcTag;
  } exp_t;

  exp_t        exq[$];
  logic [31:0] wq[$];
  logic [15:0] hq[$];
  int          checks = 0;
  int          fails  = 0;
  logic [15:0] lfsr   = 16'hACE1;
  bit          gapMode   = 0;
  bit          stallMode = 0;
  bit          prevStall = 0;
  logic [31:0] prevPc    = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // mode 0: all 32-bit, 1: all compressed, 2: mixed
  task automatic buildProgram(input int n, input int mode);
    hq.delete();
    for (int i = 0; i < n; i++) begin
      stepLfsr();
      if (mode == 1 || (mode == 2 && lfsr[0])) begin
        hq.push_back({lfsr[15:2], lfsr[1], 1'b0});
      end else begin
        hq.push_back({lfsr[15:2], 2'b11});
        hq.push_back(lfsr ^ 16'h5A5A);
      end
    end
  endtask

  // driver side: words to feed and instructions expected from them
  task automatic loadStream(input logic [31:0] target, input bit dangling, input string firstTag);
    logic [15:0] s[$];
    logic [31:0] a;
    logic [31:0] pc;
    int          p;
    bit          first;
    exp_t        e;
    a = target & ~32'h1;
    if (a[1]) s.push_back(16'h4001);  // filler that looks compressed (R8)
    foreach (hq[i]) s.push_back(hq[i]);
    if (s.size() % 2 != 0) s.push_back(16'h0005);
    if (dangling) begin
      s.push_back(16'h0009);
      s.push_back(16'h7FFF);  // 32-bit start with nothing after it (R6)
    end
    for (int k = 0; k < s.size() / 2; k++) wq.push_back({s[2*k+1], s[2*k]});
    p     = a[1] ? 1 : 0;
    pc    = a;
    first = 1;
    while (p < s.size()) begin
      if (s[p][1:0] != 2'b11) begin
        e.instr   = {16'h0000, s[p]};
        e.comp    = 1;
        e.fromRes = (p % 2) == 1;
        e.tag     = e.fromRes ? "R5" : "R4";
        e.pc      = pc;
        pc += 2;
        p  += 1;
      end else if (p + 1 < s.size()) begin
        e.instr   = {s[p+1], s[p]};
        e.comp    = 0;
        e.fromRes = 0;
        e.tag     = (p % 2) == 1 ? "R6" : "R3";
        e.pc      = pc;
        pc += 4;
        p  += 2;
      end else begin
        break;
      end
      e.pcTag = first ? firstTag : "R10";
      if (first) e.tag = firstTag;
      first = 0;
      exq.push_back(e);
    end
  endtask

  task automatic doRedirect(input logic [31:0] target);
    @(negedge clk);
    fetchValid = 0;
    redirValid = 1;
    redirPc    = target;
    wq.delete();
    #1.5;
    check(!outValid && !fetchReady, "R7", {30'd0, outValid, fetchReady}, 32'd0,
          "redirect cycle outValid/fetchReady");
    @(negedge clk);
    redirValid = 0;
  endtask

  task automatic runScenario(input bit dangling);
    int guard = 0;
    while ((exq.size() > 0 || wq.size() > 0) && guard < 5000) begin
      @(negedge clk);
      stepLfsr();
      fetchValid = (wq.size() > 0) && (!gapMode || lfsr[0] || lfsr[5]);
      fetchWord  = (wq.size() > 0) ? wq[0] : 32'h0;
      outReady   = !stallMode || lfsr[3];
      guard++;
    end
    @(negedge clk);
    fetchValid = 0;
    outReady   = 1;
    repeat (4) @(negedge clk);
    #1.5;
    check(exq.size() == 0, "R10", exq.size(), 0, "instructions never delivered");
    if (dangling) check(!outValid, "R6", {31'd0, outValid}, 32'd0, "dangling 32-bit start shown");
  endtask

  // monitor: retire fetched words and compare delivered instructions
  initial begin
    exp_t e;
    logic [31:0] dummy;
    forever begin
      @(negedge clk);
      #1.5;
      if (rstN) begin
        if (fetchValid && fetchReady && wq.size() > 0) dummy = wq.pop_front();
        if (outValid && outReady) begin
          if (exq.size() == 0) begin
            check(0, "R6", outInstr, 32'h0, "unexpected instruction");
          end else begin
            e = exq.pop_front();
            check(outInstr == e.instr, e.tag, outInstr, e.instr, "instruction");
            check(outCompressed == e.comp, "R2", {31'd0, outCompressed}, {31'd0, e.comp}, "compressed flag");
            check(outPc == e.pc, e.pcTag, outPc, e.pc, "pc");
            if (e.fromRes) check(!fetchReady, "R5", {31'd0, fetchReady}, 32'd0, "word pulled for residual");
          end
        end
        if (prevStall && outValid) check(outPc == prevPc, "R9", outPc, prevPc, "pc moved under stall");
        prevStall = outValid && !outReady;
        prevPc    = outPc;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rstN       = 0;
    fetchValid = 0;
    fetchWord  = '0;
    redirValid = 0;
    redirPc    = '0;
    outReady   = 1;
    repeat (4) @(negedge clk);
    #1.5;
    check(!outValid, "R1", {31'd0, outValid}, 32'd0, "valid in reset");
    @(negedge clk);
    rstN = 1;
    #1.5;
    check(!outValid, "R1", {31'd0, outValid}, 32'd0, "valid after reset");

    // aligned 32-bit stream from boot address
    buildProgram(8, 0);
    loadStream(BOOT, 0, "R1");
    runScenario(0);

    // all compressed
    doRedirect(32'h200);
    buildProgram(12, 1);
    loadStream(32'h200, 0, "R7");
    runScenario(0);

    // mixed, half-word target, fetch gaps
    gapMode = 1;
    doRedirect(32'h302);
    buildProgram(20, 2);
    loadStream(32'h302, 0, "R8");
    runScenario(0);

    // mixed, bit 0 set in target, stalls, dangling tail
    stallMode = 1;
    doRedirect(32'h407);
    buildProgram(24, 2);
    loadStream(32'h407, 1, "R8");
    runScenario(1);

    // residual left behind must be gone
    gapMode   = 0;
    stallMode = 0;
    doRedirect(32'h500);
    buildProgram(6, 2);
    loadStream(32'h500, 0, "R7");
    runScenario(0);

    // hand-made boundary: stitched start right after dropped half
    doRedirect(32'h602);
    hq.delete();
    hq.push_back(16'h1233);
    hq.push_back(16'hABCD);
    hq.push_back(16'h0010);
    hq.push_back(16'h5677);
    hq.push_back(16'h9999);
    loadStream(32'h602, 0, "R8");
    runScenario(0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule